// File: doc/BRIEF.md
# Bfloat16 Conversion and Classification Unit

This unit sits beside a floating-point datapath and handles the format traffic between IEEE single precision and bfloat16. One side takes a 32-bit single-precision word and narrows it to 16 bits with round-to-nearest, ties to even. Words whose exponent field is all ones (infinities and NaNs) are not rounded. Their upper half is passed through as it stands, and no NaN is quieted or rewritten.

The other side takes a bfloat16 word and does two things. It widens the word to single precision by appending sixteen zero bits, and it raises one of three class flags: NaN, infinity or zero. The zero flag ignores the sign.

A parameter places all results behind one output register with a valid bit, or leaves the unit purely combinational. The register stage is on by default. It uses a synchronous active-high reset that clears every output.

Top module: `bf16_cvt_unit`

## Requirements
- R1: When single-precision bits 30:23 are all ones, the narrowed result is input bits 31:16 unchanged. For example, 0x7F800001 narrows to 0x7F80 and 0xFFC12345 narrows to 0xFFC1.
- R2: Otherwise the narrowed result is input bits 31:16 rounded on input bits 15:0. It rounds up when bits 15:0 exceed 0x8000 and down when they are below 0x8000. On exactly 0x8000 it rounds up only if bit 16 is one (ties to even).
- R3: A rounding carry is allowed to reach the exponent. It turns the largest finite values into infinity: 0x7F7FFFFF narrows to 0x7F80 and 0xFF7FFFFF narrows to 0xFF80.
- R4: The widened output is the bfloat16 input in bits 31:16, with bits 15:0 equal to zero.
- R5: The NaN flag (flag_nan) is one exactly when bfloat16 bits 14:7 are all ones and bits 6:0 are nonzero.
- R6: The infinity flag (flag_inf) is one exactly when bfloat16 bits 14:7 are all ones and bits 6:0 are zero.
- R7: The zero flag (flag_zero) is one exactly when bfloat16 bits 14:0 are zero, for either value of bit 15. At most one of the three flags is ever one.
- R8: With REG_OUT=1, every output, out_valid included, shows the result for the inputs of the previous clock edge. out_valid equals in_valid from one clock earlier.
- R9: With REG_OUT=1, a clock edge with rst high sets every output to zero.
- R10: The canonical NaN 0x7FC0 takes no special path. Widened it gives 0x7FC00000 with only flag_nan set, and single-precision 0x7FC00000 narrows back to 0x7FC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks the current inputs as meaningful |
| sp_in | input | 32 | Single-precision word to narrow |
| bf_in | input | 16 | Bfloat16 word to widen and classify |
| out_valid | output | 1 | in_valid delayed to line up with the results |
| bf_out | output | 16 | Narrowed, rounded bfloat16 result |
| sp_out | output | 32 | Widened single-precision result |
| flag_nan | output | 1 | bf_in is a NaN |
| flag_inf | output | 1 | bf_in is an infinity of either sign |
| flag_zero | output | 1 | bf_in is a zero of either sign |

## Verification
The hardest case to reach is the tie: the lower sixteen bits must be exactly 0x8000. Random operands almost never land there, and reaching it means looking at bit 16. A close second is the rounding carry that rolls a finite maximum over into infinity. The stimulus builds these operands directly: ties with both parities of bit 16, the two signed finite maxima, and special exponents carrying low bits that the ordinary rounding path would otherwise have carried upward. A long run of pseudo-random words follows, compared against a reference model that decides rounding by comparing the low half, not by adding a bias.

// File: rtl/bf16_pkg.sv
package bf16_pkg;
  localparam int SP_W     = 32;
  localparam int BF_W     = 16;
  localparam int EXP_W    = 8;
  localparam int BF_MAN_W = BF_W - EXP_W - 1;
  localparam int DROP_W   = SP_W - BF_W;

  typedef struct packed {
    logic is_nan;
    logic is_inf;
    logic is_zero;
  } bf_class_t;
endpackage

// File: rtl/bf16_narrow.sv
module bf16_narrow
  import bf16_pkg::*;
(
  input  logic [SP_W-1:0] sp_in,
  output logic [BF_W-1:0] bf_out
);
  localparam logic [SP_W-1:0] HALF_M1 = (SP_W'(1) << (DROP_W - 1)) - SP_W'(1);

  logic [EXP_W-1:0] exp_f;
  logic             special;
  logic [SP_W-1:0]  bias;
  logic [SP_W-1:0]  sum;

  always_comb begin
    exp_f   = sp_in[SP_W-2 -: EXP_W];
    special = &exp_f;
    // the carry may run into the exponent; that is the intended overflow to infinity
    bias    = HALF_M1 + SP_W'(sp_in[DROP_W]);
    sum     = sp_in + bias;
    bf_out  = special ? sp_in[SP_W-1 -: BF_W] : sum[SP_W-1 -: BF_W];
  end
endmodule

// File: rtl/bf16_widen_classify.sv
module bf16_widen_classify
  import bf16_pkg::*;
(
  input  logic [BF_W-1:0] bf_in,
  output logic [SP_W-1:0] sp_out,
  output bf_class_t       cls
);
  logic [EXP_W-1:0]    exp_f;
  logic [BF_MAN_W-1:0] man_f;
  logic                exp_max;
  logic                man_nz;

  always_comb begin
    sp_out      = {bf_in, {DROP_W{1'b0}}};
    exp_f       = bf_in[BF_W-2 -: EXP_W];
    man_f       = bf_in[BF_MAN_W-1:0];
    exp_max     = &exp_f;
    man_nz      = |man_f;
    cls.is_nan  = exp_max & man_nz;
    cls.is_inf  = exp_max & ~man_nz;
    cls.is_zero = ~|bf_in[BF_W-2:0];
  end
endmodule

// File: rtl/bf16_cvt_unit.sv
module bf16_cvt_unit
  import bf16_pkg::*;
#(
  parameter bit REG_OUT = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] sp_in,
  input  logic [15:0] bf_in,
  output logic        out_valid,
  output logic [15:0] bf_out,
  output logic [31:0] sp_out,
  output logic        flag_nan,
  output logic        flag_inf,
  output logic        flag_zero
);
  logic [BF_W-1:0] nar_d;
  logic [SP_W-1:0] wid_d;
  bf_class_t       cls_d;

  bf16_narrow u_narrow (
    .sp_in  (sp_in),
    .bf_out (nar_d)
  );

  bf16_widen_classify u_widen (
    .bf_in  (bf_in),
    .sp_out (wid_d),
    .cls    (cls_d)
  );

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk) begin
        if (rst) begin
          out_valid <= 1'b0;
          bf_out    <= '0;
          sp_out    <= '0;
          flag_nan  <= 1'b0;
          flag_inf  <= 1'b0;
          flag_zero <= 1'b0;
        end else begin
          out_valid <= in_valid;
          bf_out    <= nar_d;
          sp_out    <= wid_d;
          flag_nan  <= cls_d.is_nan;
          flag_inf  <= cls_d.is_inf;
          flag_zero <= cls_d.is_zero;
        end
      end
    end else begin : g_comb
      assign out_valid = in_valid;
      assign bf_out    = nar_d;
      assign sp_out    = wid_d;
      assign flag_nan  = cls_d.is_nan;
      assign flag_inf  = cls_d.is_inf;
      assign flag_zero = cls_d.is_zero;
    end
  endgenerate
endmodule

// File: rtl/bf16_cvt_checker.sv
module bf16_cvt_checker #(
  parameter bit REG_OUT = 1'b1
) (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic [31:0] sp_in,
  input logic [15:0] bf_in,
  input logic        out_valid,
  input logic [15:0] bf_out,
  input logic [31:0] sp_out,
  input logic        flag_nan,
  input logic        flag_inf,
  input logic        flag_zero
);
  // flags never overlap (R7)
  assert_flags_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({flag_nan, flag_inf, flag_zero}));

  // low half of the widened word is always zero (R4)
  assert_widen_low_zero_R4: assert property (@(posedge clk) disable iff (rst)
    sp_out[15:0] == 16'h0000);

  generate
    if (REG_OUT) begin : g_seq
      assert_valid_delay_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> out_valid == $past(in_valid));

      assert_widen_upper_R4: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> sp_out[31:16] == $past(bf_in));

      assert_special_truncate_R1: assert property (@(posedge clk) disable iff (rst)
        (&sp_in[30:23]) |=> bf_out == $past(sp_in[31:16]));

      assert_zero_flag_R7: assert property (@(posedge clk) disable iff (rst)
        (bf_in[14:0] == 15'h0000) |=> flag_zero);

      assert_reset_clears_R9: assert property (@(posedge clk)
        rst |=> (!out_valid && bf_out == 16'h0 && sp_out == 32'h0
                 && !flag_nan && !flag_inf && !flag_zero));
    end else begin : g_cmb
      assert_valid_pass_R8: assert property (@(posedge clk) disable iff (rst)
        out_valid == in_valid);

      assert_special_truncate_R1: assert property (@(posedge clk) disable iff (rst)
        (&sp_in[30:23]) |-> bf_out == sp_in[31:16]);
    end
  endgenerate
endmodule

bind bf16_cvt_unit bf16_cvt_checker #(.REG_OUT(REG_OUT)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .sp_in     (sp_in),
  .bf_in     (bf_in),
  .out_valid (out_valid),
  .bf_out    (bf_out),
  .sp_out    (sp_out),
  .flag_nan  (flag_nan),
  .flag_inf  (flag_inf),
  .flag_zero (flag_zero)
);

// File: tb/sim_bf16_cvt_unit.sv
module sim_bf16_cvt_unit;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] sp_in;
  logic [15:0] bf_in;
  logic        out_valid;
  logic [15:0] bf_out;
  logic [31:0] sp_out;
  logic        flag_nan, flag_inf, flag_zero;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bf16_cvt_unit #(.REG_OUT(1'b1)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .sp_in(sp_in), .bf_in(bf_in),
    .out_valid(out_valid), .bf_out(bf_out), .sp_out(sp_out),
    .flag_nan(flag_nan), .flag_inf(flag_inf), .flag_zero(flag_zero)
  );

  // reference narrowing: decide by comparing the discarded half
  function automatic logic [15:0] ref_narrow(input logic [31:0] x);
    logic [15:0] hi, lo;
    logic        up;
    hi = x[31:16];
    lo = x[15:0];
    if (x[30:23] == 8'hFF) return hi;
    if (lo > 16'h8000)       up = 1'b1;
    else if (lo < 16'h8000)  up = 1'b0;
    else                     up = hi[0];
    return hi + {15'd0, up};
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // drive at falling edge, result visible after the next rising edge
  task automatic apply(input logic [31:0] s, input logic [15:0] b, input logic v);
    @(negedge clk);
    sp_in = s; bf_in = b; in_valid = v;
    @(negedge clk);
  endtask

  task automatic narrow_case(input string req, input logic [31:0] s, input logic [15:0] exp);
    apply(s, 16'h0000, 1'b1);
    check(req, "narrow", {16'h0, bf_out}, {16'h0, exp});
    check(req, "narrow-model", {16'h0, exp}, {16'h0, ref_narrow(s)});
  endtask

  task automatic class_case(input string req, input logic [15:0] b,
                            input logic n, input logic i, input logic z);
    apply(32'h0, b, 1'b1);
    check(req, "flags", {29'd0, flag_nan, flag_inf, flag_zero}, {29'd0, n, i, z});
    check("R4", "widen", sp_out, {b, 16'h0000});
  endtask

  task automatic t_reset;
    rst = 1'b1; in_valid = 1'b1; sp_in = 32'h3F812345; bf_in = 16'h7FC0;
    @(negedge clk); @(negedge clk);
    check("R9", "valid", {31'd0, out_valid}, 32'd0);
    check("R9", "bf_out", {16'h0, bf_out}, 32'd0);
    check("R9", "sp_out", sp_out, 32'd0);
    check("R9", "flags", {29'd0, flag_nan, flag_inf, flag_zero}, 32'd0);
    rst = 1'b0;
  endtask

  task automatic t_special;
    narrow_case("R1", 32'h7F800001, 16'h7F80);
    narrow_case("R1", 32'hFFC12345, 16'hFFC1);
    narrow_case("R1", 32'h7FFFFFFF, 16'h7FFF);
    narrow_case("R1", 32'hFF80FFFF, 16'hFF80);
  endtask

  task automatic t_round;
    narrow_case("R2", 32'h3F808001, 16'h3F81);
    narrow_case("R2", 32'h3F807FFF, 16'h3F80);
    narrow_case("R2", 32'h3F808000, 16'h3F80);
    narrow_case("R2", 32'h3F818000, 16'h3F82);
    narrow_case("R2", 32'hBF818000, 16'hBF82);
    narrow_case("R2", 32'h00000000, 16'h0000);
    narrow_case("R2", 32'h80000000, 16'h8000);
  endtask

  task automatic t_carry;
    narrow_case("R3", 32'h7F7FFFFF, 16'h7F80);
    narrow_case("R3", 32'hFF7FFFFF, 16'hFF80);
    narrow_case("R3", 32'h3FFF8000, 16'h4000);
  endtask

  task automatic t_classify;
    class_case("R5", 16'h7F81, 1'b1, 1'b0, 1'b0);
    class_case("R5", 16'hFFFF, 1'b1, 1'b0, 1'b0);
    class_case("R6", 16'h7F80, 1'b0, 1'b1, 1'b0);
    class_case("R6", 16'hFF80, 1'b0, 1'b1, 1'b0);
    class_case("R7", 16'h0000, 1'b0, 1'b0, 1'b1);
    class_case("R7", 16'h8000, 1'b0, 1'b0, 1'b1);
    class_case("R7", 16'h0001, 1'b0, 1'b0, 1'b0);
    class_case("R7", 16'h3F80, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_canon_nan;
    apply(32'h7FC00000, 16'h7FC0, 1'b1);
    check("R10", "widen", sp_out, 32'h7FC00000);
    check("R10", "flags", {29'd0, flag_nan, flag_inf, flag_zero}, {29'd0, 3'b100});
    check("R10", "narrow", {16'h0, bf_out}, {16'h0, 16'h7FC0});
  endtask

  task automatic t_valid;
    apply(32'h0, 16'h0, 1'b0);
    check("R8", "valid low", {31'd0, out_valid}, 32'd0);
    apply(32'h0, 16'h0, 1'b1);
    check("R8", "valid high", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    sp_in = 32'h3F808001; in_valid = 1'b0;
    @(posedge clk); #1;
    check("R8", "one-clock latency", {16'h0, bf_out}, {16'h0, 16'h3F81});
    check("R8", "valid drop", {31'd0, out_valid}, 32'd0);
  endtask

  task automatic t_sweep;
    logic [31:0] lfsr;
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 2000; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      apply(lfsr, lfsr[15:0] ^ lfsr[31:16], 1'b1);
      check("R2", "sweep narrow", {16'h0, bf_out}, {16'h0, ref_narrow(lfsr)});
      check("R4", "sweep widen", sp_out, {lfsr[15:0] ^ lfsr[31:16], 16'h0});
    end
  endtask

  initial begin
    t_reset();
    t_special();
    t_round();
    t_carry();
    t_classify();
    t_canon_nan();
    t_valid();
    t_sweep();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < WATCHDOG; c++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule